// File: doc/BRIEF.md
# Multi-Bank Asynchronous DRAM Controller with CAS-before-RAS Refresh

This block sits between a single CPU-side bus master and up to six banks of asynchronous 16-bit DRAM. A request carries a 28-bit byte address, a read/write flag and two byte enables. The block compares the upper address bits with the programmed window of every bank. It then drives the matching bank's row strobe with the row address and the shared column strobes with the column address. After the programmed number of clocks it returns a one-cycle acknowledge. A request that falls in no enabled window gets a one-cycle bus error instead.

Each bank has its own configuration word. The word holds a window start in 512 KB units, a size code, a timing code and an enable bit. A separate 12-bit register sets the refresh interval. Refresh uses CAS-before-RAS cycles on all six row strobes together, so the DRAM supplies the row address itself. Refresh starts right after reset, before any bank has been configured. A refresh that is due wins over a waiting request, but it never cuts into an access that is already running.

Top module: `dram_bank_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, every row strobe, both column strobes and write enable are high, and acknowledge and bus error are low.
- R2: Bank word fields are: window start in bits 8..0 (matched against address bits 27..19), size code in bits 10..9 (0 = 512 KB, 1 = 2 MB, 2 = 8 MB, 3 = never matches), timing code in bits 12..11, and enable in bit 15. Words are written with cfg_idx 0..5. A bank matches when it is enabled and address bits 27..19 lie in [start, start + size/512 KB). The lowest-numbered match wins, and only that bank's row strobe goes low.
- R3: A request that matches no bank gets a one-cycle bus error. No row or column strobe goes low for it.
- R4: The word offset is bits 22..1 of (address − start·512 KB). The column width is 9, 10 or 11 bits for size codes 0, 1 and 2. The row address is the offset shifted right by the column width, masked to the same width. The row address is on ma while the row strobe alone is low, and the column address is on ma while the column strobes are low.
- R5: Timing code 0, 1 and 2/3 give 2, 3 and 4 clocks. The row strobe is low for that many cycles and the column strobes for one cycle fewer. Acknowledge is high for one cycle, in the cycle where all strobes return high.
- R6: The upper column strobe goes low only if ube is set, and the lower only if lbe is set. Write enable is low together with the column strobes for a write and stays high for a read.
- R7: All banks are disabled after reset, so an access before any configuration ends in a bus error.
- R8: In a refresh, both column strobes fall one cycle before all six row strobes fall together. The row strobes stay low for 3 cycles, then all strobes rise together.
- R9: The refresh interval register (cfg_idx 6, bits 11..0) defaults to 256. Successive refreshes start exactly one interval apart while no access delays them, and the first refresh occurs about 256 cycles after reset without any configuration.
- R10: When a refresh is due in the same cycle that a request waits, the refresh starts first. A refresh never begins while a bank's row strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Register index: 0..5 bank words, 6 refresh interval |
| cfg_data | input | 16 | Configuration write data |
| req | input | 1 | Access request, held until ack or berr |
| addr | input | 28 | Byte address |
| wr | input | 1 | 1 = write, 0 = read |
| ube | input | 1 | Upper byte enable |
| lbe | input | 1 | Lower byte enable |
| ack | output | 1 | Access done, one cycle |
| berr | output | 1 | No bank matched, one cycle |
| ras_n | output | 6 | Row strobes, one per bank, active low |
| ucas_n | output | 1 | Upper column strobe, active low |
| lcas_n | output | 1 | Lower column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ma | output | 11 | Multiplexed row/column address |

## Verification
The embedded properties assume four things about the inputs. The master holds req, addr, wr and the byte enables steady until ack or berr, and drops req in the cycle it sees them. Configuration writes arrive only between accesses. Every write has at least one byte enable. The refresh interval exceeds the length of a refresh plus one access. The bench keeps to these rules by design. Its access task raises req only after the previous response, clears it on the sampling edge that shows ack or berr, and picks byte enables from the non-zero pairs. It writes configuration only between accesses, and the smallest interval it programs is 80.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  // width of one bank configuration word and the window granule (512 KB)
  localparam int BANK_RW = 16;
  localparam int UNIT_SH = 19;
  localparam logic [1:0] SZ_NONE = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_CAS, ST_PRE, ST_ERR, ST_RFC, ST_RFH
  } dbc_st_e;

  // window span in 512 KB granules per size code
  function automatic int span_units(input logic [1:0] code);
    case (code)
      2'd0:    span_units = 1;
      2'd1:    span_units = 4;
      default: span_units = 16;
    endcase
  endfunction
endpackage

// File: rtl/dbc_refresh.sv
module dbc_refresh #(
  parameter int CNT_W  = 12,
  parameter int RF_DEF = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ivl_we,
  input  logic [CNT_W-1:0] ivl_data,
  input  logic             rf_take,
  output logic             rf_pend
);
  logic [CNT_W-1:0] ivl_q, cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ivl_q   <= CNT_W'(RF_DEF);
      cnt_q   <= CNT_W'(RF_DEF - 1);
      rf_pend <= 1'b0;
    end else begin
      if (ivl_we) ivl_q <= ivl_data;
      if (rf_take) rf_pend <= 1'b0;
      if (cnt_q == '0) begin
        cnt_q   <= ivl_q - 1'b1;
        rf_pend <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R9: a pending refresh stays pending until the sequencer takes it
  a_r9_pend_hold: assert property (@(posedge clk) disable iff (rst)
    (rf_pend && !rf_take) |=> rf_pend);
  // R9: the countdown restarts from the interval register
  a_r9_reload: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |=> (cnt_q == $past(ivl_q) - 1'b1));
endmodule

// File: rtl/dbc_decode.sv
module dbc_decode import dbc_pkg::*; #(
  parameter int NB   = 6,
  parameter int AW   = 28,
  parameter int MA_W = 11,
  parameter int SW   = 3
) (
  input  logic [NB*BANK_RW-1:0] cfg_flat,
  input  logic [AW-1:0]         addr,
  output logic                  hit,
  output logic [SW-1:0]         sel,
  output logic [MA_W-1:0]       row,
  output logic [MA_W-1:0]       col,
  output logic [2:0]            nclk
);
  localparam int BW  = AW - UNIT_SH;      // window start width
  localparam int OW  = UNIT_SH + 4;       // byte span of the largest bank
  localparam int CB0 = (UNIT_SH - 1) / 2; // column bits of the smallest bank

  logic [BW-1:0] a_hi, base_i, wbase;
  logic [BW:0]   lim_i;
  logic [1:0]    sz_i, wsz, wtm;
  logic [AW-1:0] off;
  logic [OW-2:0] woff, cmask;
  int            cb;

  always_comb begin
    a_hi   = addr[AW-1:UNIT_SH];
    hit    = 1'b0;
    sel    = '0;
    wbase  = '0;
    wsz    = '0;
    wtm    = '0;
    base_i = '0;
    sz_i   = '0;
    lim_i  = '0;
    // scan downward so the lowest matching index is assigned last
    for (int i = NB - 1; i >= 0; i--) begin
      base_i = cfg_flat[i*BANK_RW +: BW];
      sz_i   = cfg_flat[i*BANK_RW + BW +: 2];
      lim_i  = {1'b0, base_i} + (BW+1)'(span_units(sz_i));
      if (cfg_flat[i*BANK_RW + BANK_RW - 1] && (sz_i != SZ_NONE) &&
          (a_hi >= base_i) && ({1'b0, a_hi} < lim_i)) begin
        hit   = 1'b1;
        sel   = SW'(i);
        wbase = base_i;
        wsz   = sz_i;
        wtm   = cfg_flat[i*BANK_RW + BW + 2 +: 2];
      end
    end
    off   = addr - {wbase, {UNIT_SH{1'b0}}};
    woff  = off[OW-1:1];
    cb    = CB0 + int'(wsz);
    cmask = (OW-1)'((1 << cb) - 1);
    col   = MA_W'(woff & cmask);
    row   = MA_W'((woff >> cb) & cmask);
    nclk  = (wtm == 2'd0) ? 3'd2 : (wtm == 2'd1) ? 3'd3 : 3'd4;
  end
endmodule

// File: rtl/dbc_seq.sv
module dbc_seq import dbc_pkg::*; #(
  parameter int NB   = 6,
  parameter int MA_W = 11,
  parameter int SW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic            wr,
  input  logic            ube,
  input  logic            lbe,
  input  logic            hit,
  input  logic [SW-1:0]   sel,
  input  logic [MA_W-1:0] row,
  input  logic [MA_W-1:0] col,
  input  logic [2:0]      nclk,
  input  logic            rf_pend,
  output logic            rf_take,
  output logic            ack,
  output logic            berr,
  output logic [NB-1:0]   ras_n,
  output logic            ucas_n,
  output logic            lcas_n,
  output logic            we_n,
  output logic [MA_W-1:0] ma
);
  localparam logic [2:0] RF_LOW = 3'd3; // row strobe low time in a refresh

  dbc_st_e         st;
  logic [2:0]      cnt;
  logic [MA_W-1:0] col_q;
  logic [2:0]      nclk_q;
  logic            wr_q, ube_q, lbe_q;

  assign rf_take = (st == ST_IDLE) && rf_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      col_q  <= '0;
      nclk_q <= 3'd2;
      wr_q   <= 1'b0;
      ube_q  <= 1'b0;
      lbe_q  <= 1'b0;
      ack    <= 1'b0;
      berr   <= 1'b0;
      ras_n  <= '1;
      ucas_n <= 1'b1;
      lcas_n <= 1'b1;
      we_n   <= 1'b1;
      ma     <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (rf_pend) begin
            ucas_n <= 1'b0;
            lcas_n <= 1'b0;
            st     <= ST_RFC;
          end else if (req) begin
            if (hit) begin
              ras_n[sel] <= 1'b0;
              ma         <= row;
              col_q      <= col;
              nclk_q     <= nclk;
              wr_q       <= wr;
              ube_q      <= ube;
              lbe_q      <= lbe;
              st         <= ST_ROW;
            end else begin
              berr <= 1'b1;
              st   <= ST_ERR;
            end
          end
        end
        ST_ROW: begin
          ucas_n <= ~ube_q;
          lcas_n <= ~lbe_q;
          we_n   <= ~wr_q;
          ma     <= col_q;
          cnt    <= nclk_q - 3'd1;
          st     <= ST_CAS;
        end
        ST_CAS: begin
          if (cnt == 3'd1) begin
            ras_n  <= '1;
            ucas_n <= 1'b1;
            lcas_n <= 1'b1;
            we_n   <= 1'b1;
            ack    <= 1'b1;
            st     <= ST_PRE;
          end else begin
            cnt <= cnt - 3'd1;
          end
        end
        ST_RFC: begin
          ras_n <= '0;
          cnt   <= RF_LOW;
          st    <= ST_RFH;
        end
        ST_RFH: begin
          if (cnt == 3'd1) begin
            ras_n  <= '1;
            ucas_n <= 1'b1;
            lcas_n <= 1'b1;
            st     <= ST_PRE;
          end else begin
            cnt <= cnt - 3'd1;
          end
        end
        ST_PRE: begin
          ack <= 1'b0;
          st  <= ST_IDLE;
        end
        ST_ERR: begin
          berr <= 1'b0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: at most one bank strobe low, except for a refresh on all of them
  a_r2_one_bank: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ras_n) || (ras_n == {NB{1'b0}}));
  // R3: a bus error never comes with strobe activity
  a_r3_berr_quiet: assert property (@(posedge clk) disable iff (rst)
    berr |-> ((ras_n == {NB{1'b1}}) && ucas_n && lcas_n));
  // R5: acknowledge rises exactly when a bank strobe is released
  a_r5_ack_release: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> ((ras_n == {NB{1'b1}}) && ($past(ras_n) != {NB{1'b1}})));
  // R5: acknowledge and bus error are exclusive
  a_r5_ack_berr_excl: assert property (@(posedge clk) disable iff (rst)
    !(ack && berr));
  // R6: write enable is low only inside a single-bank access
  a_r6_we_in_access: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> ((ras_n != {NB{1'b1}}) && (ras_n != {NB{1'b0}})));
  // R8: column strobes lead the row strobes in a refresh
  a_r8_cbr_order: assert property (@(posedge clk) disable iff (rst)
    ((ras_n == {NB{1'b0}}) && ($past(ras_n) != {NB{1'b0}})) |->
      (!$past(ucas_n) && !$past(lcas_n)));
  // R10: a refresh starts only from a fully released strobe set
  a_r10_no_cut_in: assert property (@(posedge clk) disable iff (rst)
    ((ras_n == {NB{1'b0}}) && ($past(ras_n) != {NB{1'b0}})) |->
      ($past(ras_n) == {NB{1'b1}}));
endmodule

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl import dbc_pkg::*; #(
  parameter int NB     = 6,
  parameter int AW     = 28,
  parameter int MA_W   = 11,
  parameter int RCNT_W = 12,
  parameter int RF_DEF = 256
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [$clog2(NB+1)-1:0]    cfg_idx,
  input  logic [BANK_RW-1:0]         cfg_data,
  input  logic                       req,
  input  logic [AW-1:0]              addr,
  input  logic                       wr,
  input  logic                       ube,
  input  logic                       lbe,
  output logic                       ack,
  output logic                       berr,
  output logic [NB-1:0]              ras_n,
  output logic                       ucas_n,
  output logic                       lcas_n,
  output logic                       we_n,
  output logic [MA_W-1:0]            ma
);
  localparam int IW = $clog2(NB + 1);
  localparam int SW = (NB > 1) ? $clog2(NB) : 1;

  logic [NB*BANK_RW-1:0] cfg_flat;
  logic                  hit, rf_pend, rf_take, ivl_we;
  logic [SW-1:0]         sel;
  logic [MA_W-1:0]       row, col;
  logic [2:0]            nclk;

  // one configuration word per bank, all disabled at reset
  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [BANK_RW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else if (cfg_we && (cfg_idx == IW'(g))) word_q <= cfg_data;
    end
    assign cfg_flat[g*BANK_RW +: BANK_RW] = word_q;
  end

  assign ivl_we = cfg_we && (cfg_idx == IW'(NB));

  dbc_decode #(.NB(NB), .AW(AW), .MA_W(MA_W), .SW(SW)) u_dec (
    .cfg_flat(cfg_flat), .addr(addr), .hit(hit), .sel(sel),
    .row(row), .col(col), .nclk(nclk)
  );

  dbc_refresh #(.CNT_W(RCNT_W), .RF_DEF(RF_DEF)) u_rf (
    .clk(clk), .rst(rst), .ivl_we(ivl_we),
    .ivl_data(cfg_data[RCNT_W-1:0]), .rf_take(rf_take), .rf_pend(rf_pend)
  );

  dbc_seq #(.NB(NB), .MA_W(MA_W), .SW(SW)) u_seq (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .ube(ube), .lbe(lbe),
    .hit(hit), .sel(sel), .row(row), .col(col), .nclk(nclk),
    .rf_pend(rf_pend), .rf_take(rf_take), .ack(ack), .berr(berr),
    .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n), .ma(ma)
  );
endmodule

// File: tb/sim_dram_bank_ctrl.sv
module sim_dram_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [15:0] cfg_data = '0;
  logic        req = 1'b0;
  logic [27:0] addr = '0;
  logic        wr = 1'b0, ube = 1'b0, lbe = 1'b0;
  logic        ack, berr, ucas_n, lcas_n, we_n;
  logic [5:0]  ras_n;
  logic [10:0] ma;

  int vecs = 0, errs = 0;
  int bb[6], bs[6], bt[6];
  bit be[6];
  int cyc = 0, starts = 0, last_start = 0, last_gap = 0, first_start = 0, rlen = 0;
  bit prev_all = 0, prev_uc = 1, prev_lc = 1;

  dram_bank_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .req(req), .addr(addr), .wr(wr), .ube(ube), .lbe(lbe), .ack(ack), .berr(berr),
    .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n), .ma(ma)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // refresh monitor: ordering, length and spacing (R8, R9)
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (ras_n == 6'b0 && !prev_all) begin
        starts++;
        chk(!prev_uc && !prev_lc, "R8 cas before ras", {prev_uc, prev_lc}, 0);
        if (starts == 1) first_start = cyc;
        else last_gap = cyc - last_start;
        last_start = cyc;
        rlen = 1;
      end else if (ras_n == 6'b0) begin
        rlen++;
      end else if (prev_all) begin
        chk(rlen == 3, "R8 ras low length", rlen, 3);
        chk(ras_n == 6'h3f && ucas_n && lcas_n, "R8 release", {ras_n, ucas_n, lcas_n}, 8'hff);
      end
      prev_all = (ras_n == 6'b0);
      prev_uc  = ucas_n;
      prev_lc  = lcas_n;
    end
  end

  task automatic wr_bank(input int i, input int base, input int sz, input int tm, input bit en);
    bb[i] = base; bs[i] = sz; bt[i] = tm; be[i] = en;
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(i);
    cfg_data = {en, 2'b00, 2'(tm), 2'(sz), 9'(base)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_ivl(input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd6; cfg_data = 16'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // independent model of decode and address split (R2, R4, R5)
  function automatic void model(input logic [27:0] a, output int bk, output int n,
                                output logic [10:0] row, output logic [10:0] col);
    int u, span, cb;
    logic [27:0] off;
    logic [21:0] woff, msk;
    bk = -1; n = 0; row = '0; col = '0;
    u = int'(a[27:19]);
    for (int i = 5; i >= 0; i--) begin
      span = (bs[i] == 0) ? 1 : (bs[i] == 1) ? 4 : 16;
      if (be[i] && bs[i] != 3 && u >= bb[i] && u < bb[i] + span) bk = i;
    end
    if (bk >= 0) begin
      n    = (bt[bk] == 0) ? 2 : (bt[bk] == 1) ? 3 : 4;
      off  = a - (28'(bb[bk]) << 19);
      woff = off[22:1];
      cb   = 9 + bs[bk];
      msk  = 22'((1 << cb) - 1);
      col  = 11'(woff & msk);
      row  = 11'((woff >> cb) & msk);
    end
  endfunction

  task automatic do_acc(input logic [27:0] a, input bit w, input bit ub, input bit lb,
                        input bit prio);
    int bk, n, seen_bk, nras, ncas, k;
    logic [10:0] erow, ecol, srow, scol;
    bit got_ack, got_berr, first, cfirst, su, sl, sw;
    model(a, bk, n, erow, ecol);
    seen_bk = -1; nras = 0; ncas = 0; got_ack = 0; got_berr = 0;
    first = 1; cfirst = 1; srow = '0; scol = '0; su = 1; sl = 1; sw = 1;
    @(negedge clk);
    req = 1'b1; addr = a; wr = w; ube = ub; lbe = lb;
    for (k = 0; k < 40; k++) begin
      @(negedge clk);
      if (prio && k == 0)
        chk(ras_n == 6'h3f && !ucas_n && !lcas_n, "R10 refresh first",
            {ras_n, ucas_n, lcas_n}, {6'h3f, 2'b00});
      if ($countones(~ras_n) == 1) begin
        for (int j = 0; j < 6; j++) if (!ras_n[j]) seen_bk = j;
        nras++;
        if (first) begin srow = ma; first = 0; end
        if (!ucas_n || !lcas_n) begin
          ncas++;
          if (cfirst) begin scol = ma; su = ucas_n; sl = lcas_n; sw = we_n; cfirst = 0; end
        end
      end
      if (ack || berr) begin
        got_ack = ack; got_berr = berr;
        if (ack) chk(ras_n == 6'h3f && ucas_n && lcas_n && we_n, "R5 release with ack",
                     ras_n, 6'h3f);
        req = 1'b0;
        break;
      end
    end
    if (bk < 0) begin
      chk(got_berr && !got_ack, "R3 bus error", {got_berr, got_ack}, 2'b10);
      chk(seen_bk == -1, "R3 no bank strobe", seen_bk, -1);
    end else begin
      chk(got_ack && !got_berr, "R2 ack", {got_ack, got_berr}, 2'b10);
      chk(seen_bk == bk, "R2 bank select", seen_bk, bk);
      chk(srow == erow, "R4 row address", srow, erow);
      chk(scol == ecol, "R4 column address", scol, ecol);
      chk(nras == n, "R5 ras cycles", nras, n);
      chk(ncas == n - 1, "R5 cas cycles", ncas, n - 1);
      chk(su == !ub && sl == !lb, "R6 byte strobes", {su, sl}, {!ub, !lb});
      chk(sw == !w, "R6 write enable", sw, !w);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int v, u;
    logic [27:0] a;
    void'($urandom(32'd2024));
    for (int i = 0; i < 6; i++) begin bb[i] = 0; bs[i] = 0; bt[i] = 0; be[i] = 0; end
    repeat (4) @(negedge clk);
    chk(ras_n == 6'h3f && ucas_n && lcas_n && we_n && !ack && !berr, "R1 in reset",
        {ras_n, ucas_n, lcas_n, we_n, ack, berr}, 11'h7fc);
    rst = 1'b0;
    @(negedge clk);
    chk(ras_n == 6'h3f && ucas_n && lcas_n && we_n && !ack && !berr, "R1 after reset",
        {ras_n, ucas_n, lcas_n, we_n, ack, berr}, 11'h7fc);

    // R7: nothing configured, access must fail
    do_acc(28'h0000100, 1'b0, 1'b1, 1'b1, 1'b0);

    // R9: refresh runs unconfigured at the default interval
    while (starts < 2) @(negedge clk);
    chk(first_start >= 250 && first_start <= 262, "R9 first refresh", first_start, 258);
    chk(last_gap == 256, "R9 default interval", last_gap, 256);

    // directed windows (R2 priority, size codes, disabled bank)
    wr_bank(0, 0, 1, 0, 1);
    wr_bank(1, 2, 0, 1, 1);
    wr_bank(2, 16, 2, 2, 1);
    wr_bank(3, 40, 3, 1, 1);
    wr_bank(4, 64, 0, 3, 0);
    wr_bank(5, 100, 0, 1, 1);
    do_acc(28'h0000002, 1'b1, 1'b1, 1'b1, 1'b0);
    do_acc(28'h0100A46, 1'b0, 1'b0, 1'b1, 1'b0);
    do_acc(28'h01FFFFE, 1'b1, 1'b1, 1'b0, 1'b0);
    do_acc(28'h0200000, 1'b0, 1'b1, 1'b1, 1'b0);
    do_acc(28'h0FFFFFE, 1'b0, 1'b1, 1'b1, 1'b0);
    do_acc(28'h1000000, 1'b1, 1'b1, 1'b1, 1'b0);
    do_acc(28'h1400010, 1'b0, 1'b1, 1'b1, 1'b0);
    do_acc(28'h2000010, 1'b0, 1'b1, 1'b1, 1'b0);
    do_acc(28'h3200ABC, 1'b1, 1'b0, 1'b1, 1'b0);

    // constrained random: reshuffled windows every 25 accesses
    for (int r = 0; r < 150; r++) begin
      if (r % 25 == 0)
        for (int i = 0; i < 6; i++)
          wr_bank(i, $urandom_range(0, 63), $urandom_range(0, 3),
                  $urandom_range(0, 3), ($urandom_range(0, 3) != 0));
      u = $urandom_range(0, 79);
      a = (28'(u) << 19) | (28'($urandom) & 28'h7FFFE);
      v = $urandom_range(1, 3);
      do_acc(a, 1'($urandom_range(0, 1)), v[1], v[0], 1'b0);
    end

    // R9: reprogrammed interval
    wr_ivl(80);
    repeat (400) @(negedge clk);
    chk(last_gap == 80, "R9 programmed interval", last_gap, 80);

    // R10: request raised in the cycle a refresh falls due
    wr_bank(5, 100, 0, 2, 1);
    do @(negedge clk); while (ras_n != 6'b0);
    repeat (77) @(negedge clk);
    do_acc(28'h3200040, 1'b0, 1'b1, 1'b1, 1'b1);
    repeat (20) @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule